// File: doc/BRIEF.md
# Card Presence Debounce and Fault Supervisor

This block watches the two card-detect contacts of a smart-card socket and a set of protection flags coming from the card power path. It turns the noisy contacts into one debounced card-present signal. It raises an internal alarm that tells the power sequencer to shut the card down. It also drives one status line to the host that is high only when the slot is ready for a session.

The contacts have opposite polarity, and either one alone is enough to signal a card. Presence changes only after the contacts have agreed for a fixed number of milliseconds. The millisecond unit comes from a prescaler on the system clock. After power-on reset the alarm is held for a settling wait of 8 ms or 16 ms, chosen by a parameter.

Each protection flag is synchronised and then latched into a sticky fault bit. A card removal is latched the same way. The sticky bit, and so the alarm, clears only when three things hold together: a card is present, no fault flag is active, and the host holds its command line high, which means "deactivated".

Top module: `card_supervisor`

## Requirements
- R1: A card counts as present when `presHiIn` is 1 or `presLoIn` is 0. Either contact alone is enough.
- R2: `cardPresent` changes only after the contact state has differed from it for `DEBOUNCE_MS` consecutive millisecond ticks, where one tick is `CLK_PER_MS` clock cycles.
- R3: After reset, `alarm` stays 1 and `readyOut` stays 0 until 8 ms have elapsed (`LONG_POR`=0) or 16 ms have elapsed (`LONG_POR`=1).
- R4: Any of the four fault inputs (undervoltage, overtemperature, card-supply short or overcurrent, charge-pump failure) drives `readyOut` to 0 within 3 cycles. The fault stays latched after the flag drops.
- R5: A debounced card removal raises `alarm` and latches a fault.
- R6: `readyOut` returns to 1 only when a card is present, no fault flag is active, and `hostCmdIn` is 1. A latched fault stays set while `hostCmdIn` is 0.
- R7: A contact bounce shorter than the debounce period neither changes `cardPresent` nor raises `alarm`.
- R8: `readyOut` is always the inverse of `alarm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| presHiIn | input | 1 | Card-detect contact, active high |
| presLoIn | input | 1 | Card-detect contact, active low |
| fltUnderVolt | input | 1 | Supply undervoltage flag |
| fltOverTemp | input | 1 | Overtemperature flag |
| fltCardSupply | input | 1 | Card supply short or overcurrent flag |
| fltPump | input | 1 | Charge pump failure flag |
| hostCmdIn | input | 1 | Host command line; 1 = deactivated or idle |
| alarm | output | 1 | Internal alarm to the power sequencer |
| readyOut | output | 1 | Host status; 1 = ready, 0 = off or fault |
| cardPresent | output | 1 | Debounced card presence |

## Verification
A sticky bit that fails to set shows at the ports as `readyOut` coming back as soon as a fault flag drops while the host line is still low. That error appears within three cycles of the flag's release. A debounce counter that never clears on a returning contact shows as a removal alarm after a short bounce, about one debounce period later. A power-on counter with the wrong limit moves the first rise of `readyOut` by whole milliseconds. The bench therefore checks `readyOut` at times that fall between the 8 ms and 16 ms bounds.

// File: rtl/card_sup_pkg.sv
package card_sup_pkg;

  localparam int NUM_FAULTS = 4;

  // Observations from the datapath to the control
  typedef struct packed {
    logic msTick;
    logic rawPresent;
    logic faultAny;
    logic hostHigh;
    logic debExpired;
    logic porExpired;
    logic cardPresent;
  } sup_obs_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic debClear;
    logic debStep;
    logic presToggle;
    logic porStep;
  } sup_ctl_t;

endpackage

// File: rtl/card_sup_datapath.sv
module card_sup_datapath
  import card_sup_pkg::*;
#(
  parameter int CLK_PER_MS  = 20000,
  parameter int DEBOUNCE_MS = 8,
  parameter int POR_MS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  presHiIn,
  input  logic                  presLoIn,
  input  logic [NUM_FAULTS-1:0] faultIn,
  input  logic                  hostCmdIn,
  input  sup_ctl_t              ctl,
  output sup_obs_t              obs
);

  localparam int TICK_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int DEB_W  = $clog2(DEBOUNCE_MS + 1);
  localparam int POR_W  = $clog2(POR_MS + 1);
  localparam int SYNC_W = NUM_FAULTS + 3;
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(CLK_PER_MS - 1);
  localparam logic [DEB_W-1:0]  DEB_LIM  = DEB_W'(DEBOUNCE_MS);
  localparam logic [POR_W-1:0]  POR_LIM  = POR_W'(POR_MS);
  // Idle levels: host high, active-low contact high, active-high contact low, no faults
  localparam logic [SYNC_W-1:0] SYNC_IDLE = {1'b1, 1'b1, 1'b0, {NUM_FAULTS{1'b0}}};

  logic [SYNC_W-1:0] syncStage [SYNC_STAGES];
  logic [SYNC_W-1:0] rawBus, syncOut;
  logic [TICK_W-1:0] tickCnt;
  logic [DEB_W-1:0]  debCnt;
  logic [POR_W-1:0]  porCnt;
  logic              presentQ;

  assign rawBus  = {hostCmdIn, presLoIn, presHiIn, faultIn};
  assign syncOut = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= SYNC_IDLE;
    end else begin
      syncStage[0] <= rawBus;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
    end
  end

  // Millisecond prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tickCnt <= '0;
    else if (tickCnt == TICK_MAX) tickCnt <= '0;
    else                        tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              debCnt <= '0;
    else if (ctl.debClear || ctl.presToggle) debCnt <= '0;
    else if (ctl.debStep)                   debCnt <= debCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            porCnt <= '0;
    else if (ctl.porStep) porCnt <= porCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               presentQ <= 1'b0;
    else if (ctl.presToggle) presentQ <= ~presentQ;
  end

  assign obs.msTick      = (tickCnt == TICK_MAX);
  assign obs.rawPresent  = syncOut[NUM_FAULTS] | ~syncOut[NUM_FAULTS+1];
  assign obs.faultAny    = |syncOut[NUM_FAULTS-1:0];
  assign obs.hostHigh    = syncOut[NUM_FAULTS+2];
  assign obs.debExpired  = (debCnt == DEB_LIM);
  assign obs.porExpired  = (porCnt == POR_LIM);
  assign obs.cardPresent = presentQ;

endmodule

// File: rtl/card_sup_control.sv
module card_sup_control
  import card_sup_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  sup_obs_t obs,
  output sup_ctl_t ctl,
  output logic     faultSticky,
  output logic     alarm
);

  logic mismatch, removal, setSticky, clrSticky;

  always_comb begin
    mismatch       = obs.rawPresent ^ obs.cardPresent;
    ctl.debClear   = ~mismatch;
    ctl.debStep    = mismatch & obs.msTick & ~obs.debExpired;
    ctl.presToggle = mismatch & obs.debExpired;
    ctl.porStep    = obs.msTick & ~obs.porExpired;
    removal        = ctl.presToggle & obs.cardPresent;
    setSticky      = obs.faultAny | removal;
    clrSticky      = obs.cardPresent & obs.hostHigh & ~obs.faultAny;
  end

  // Set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          faultSticky <= 1'b0;
    else if (setSticky) faultSticky <= 1'b1;
    else if (clrSticky) faultSticky <= 1'b0;
  end

  assign alarm = ~obs.porExpired | ~obs.cardPresent | faultSticky;

endmodule

// File: rtl/card_supervisor.sv
module card_supervisor
  import card_sup_pkg::*;
#(
  parameter int CLK_PER_MS  = 20000,
  parameter int DEBOUNCE_MS = 8,
  parameter bit LONG_POR    = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic presHiIn,
  input  logic presLoIn,
  input  logic fltUnderVolt,
  input  logic fltOverTemp,
  input  logic fltCardSupply,
  input  logic fltPump,
  input  logic hostCmdIn,
  output logic alarm,
  output logic readyOut,
  output logic cardPresent
);

  localparam int POR_MS = LONG_POR ? 16 : 8;

  sup_obs_t obs;
  sup_ctl_t ctl;
  logic     faultSticky;
  logic     alarmInt;

  card_sup_datapath #(
    .CLK_PER_MS (CLK_PER_MS),
    .DEBOUNCE_MS(DEBOUNCE_MS),
    .POR_MS     (POR_MS),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .presHiIn (presHiIn),
    .presLoIn (presLoIn),
    .faultIn  ({fltPump, fltCardSupply, fltOverTemp, fltUnderVolt}),
    .hostCmdIn(hostCmdIn),
    .ctl      (ctl),
    .obs      (obs)
  );

  card_sup_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .obs        (obs),
    .ctl        (ctl),
    .faultSticky(faultSticky),
    .alarm      (alarmInt)
  );

  assign alarm       = alarmInt;
  assign readyOut    = ~alarmInt;
  assign cardPresent = obs.cardPresent;

endmodule

// File: rtl/card_sup_checker.sv
module card_sup_checker
  import card_sup_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input sup_obs_t obs,
  input logic     faultSticky,
  input logic     alarm,
  input logic     readyOut,
  input logic     cardPresent
);

  a_r2_hold_until_expired: assert property (@(posedge clk) disable iff (!rstN)
    !obs.debExpired |=> $stable(cardPresent));

  a_r3_alarm_in_por: assert property (@(posedge clk) disable iff (!rstN)
    !obs.porExpired |-> alarm);

  a_r4_fault_blocks_ready: assert property (@(posedge clk) disable iff (!rstN)
    obs.faultAny |=> !readyOut);

  a_r5_removal_sticks: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cardPresent) |-> faultSticky);

  a_r6_rise_conditions: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> (cardPresent && !obs.faultAny));

  a_r6_rise_needs_host: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(readyOut) && $past(faultSticky)) |-> $past(obs.hostHigh));

endmodule

bind card_supervisor card_sup_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .obs        (obs),
  .faultSticky(faultSticky),
  .alarm      (alarm),
  .readyOut   (readyOut),
  .cardPresent(cardPresent)
);

// File: tb/sim_card_supervisor.sv
module sim_card_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 4;
  localparam int NVEC       = 20;

  typedef struct packed {
    logic       presHi;
    logic       presLo;
    logic [3:0] flt;      // {pump, cardSupply, overTemp, underVolt}
    logic       host;
    logic [7:0] waitCyc;
    logic       expReady;
    logic       expCp;
    logic [3:0] req;
  } vec_t;

  // Walked in order from a slot that is ready with a card on the active-high contact
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 4'h0, 1'b1, 8'd10, 1'b1, 1'b1, 4'd1}, // R1 high contact
    '{1'b1, 1'b1, 4'h1, 1'b1, 8'd5,  1'b0, 1'b1, 4'd4}, // R4 undervoltage
    '{1'b1, 1'b1, 4'h0, 1'b0, 8'd10, 1'b0, 1'b1, 4'd6}, // R6 latched, host low
    '{1'b1, 1'b1, 4'h0, 1'b1, 8'd5,  1'b1, 1'b1, 4'd6}, // R6 host high clears
    '{1'b1, 1'b1, 4'h2, 1'b1, 8'd5,  1'b0, 1'b1, 4'd4}, // R4 overtemperature
    '{1'b1, 1'b1, 4'h0, 1'b1, 8'd5,  1'b1, 1'b1, 4'd6}, // R6
    '{1'b1, 1'b1, 4'h4, 1'b1, 8'd5,  1'b0, 1'b1, 4'd4}, // R4 card supply
    '{1'b1, 1'b1, 4'h0, 1'b1, 8'd5,  1'b1, 1'b1, 4'd6}, // R6
    '{1'b1, 1'b1, 4'h8, 1'b1, 8'd5,  1'b0, 1'b1, 4'd4}, // R4 charge pump
    '{1'b1, 1'b1, 4'h0, 1'b1, 8'd5,  1'b1, 1'b1, 4'd6}, // R6
    '{1'b0, 1'b1, 4'h0, 1'b1, 8'd10, 1'b1, 1'b1, 4'd7}, // R7 short bounce
    '{1'b1, 1'b1, 4'h0, 1'b1, 8'd50, 1'b1, 1'b1, 4'd7}, // R7 no alarm after
    '{1'b0, 1'b1, 4'h0, 1'b1, 8'd20, 1'b1, 1'b1, 4'd2}, // R2 removal not yet seen
    '{1'b0, 1'b1, 4'h0, 1'b1, 8'd30, 1'b0, 1'b0, 4'd5}, // R5 removal alarm
    '{1'b0, 1'b0, 4'h0, 1'b0, 8'd20, 1'b0, 1'b0, 4'd2}, // R2 insertion not yet seen
    '{1'b0, 1'b0, 4'h0, 1'b0, 8'd30, 1'b0, 1'b1, 4'd1}, // R1 low contact, R5 still latched
    '{1'b0, 1'b0, 4'h0, 1'b1, 8'd5,  1'b1, 1'b1, 4'd6}, // R6
    '{1'b0, 1'b0, 4'h3, 1'b0, 8'd5,  1'b0, 1'b1, 4'd4}, // R4 two flags
    '{1'b0, 1'b0, 4'h0, 1'b0, 8'd10, 1'b0, 1'b1, 4'd6}, // R6
    '{1'b0, 1'b0, 4'h0, 1'b1, 8'd5,  1'b1, 1'b1, 4'd6}  // R6
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic presHi = 1'b1, presLo = 1'b1, host = 1'b1;
  logic [3:0] flt = 4'h0;
  logic alarm0, ready0, cp0, alarm1, ready1, cp1;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_supervisor #(.CLK_PER_MS(TICK), .DEBOUNCE_MS(8), .LONG_POR(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .presHiIn(presHi), .presLoIn(presLo),
    .fltUnderVolt(flt[0]), .fltOverTemp(flt[1]), .fltCardSupply(flt[2]), .fltPump(flt[3]),
    .hostCmdIn(host), .alarm(alarm0), .readyOut(ready0), .cardPresent(cp0));

  card_supervisor #(.CLK_PER_MS(TICK), .DEBOUNCE_MS(8), .LONG_POR(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .presHiIn(presHi), .presLoIn(presLo),
    .fltUnderVolt(flt[0]), .fltOverTemp(flt[1]), .fltCardSupply(flt[2]), .fltPump(flt[3]),
    .hostCmdIn(host), .alarm(alarm1), .readyOut(ready1), .cardPresent(cp1));

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // Reset state
    waitNeg(3);
    chk("R3", "reset ready", ready0, 1'b0);
    chk("R3", "reset alarm", alarm0, 1'b1);
    chk("R2", "reset cardPresent", cp0, 1'b0);
    rstN = 1'b1;
    // Power-on wait with a card already inserted
    waitNeg(20);
    chk("R3", "u0 alarm early", alarm0, 1'b1);
    waitNeg(30);
    chk("R3", "u0 ready after 8ms", ready0, 1'b1);
    chk("R3", "u1 cardPresent", cp1, 1'b1);
    chk("R3", "u1 still waiting", ready1, 1'b0);
    waitNeg(30);
    chk("R3", "u1 ready after 16ms", ready1, 1'b1);
    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      presHi = VECS[k].presHi;
      presLo = VECS[k].presLo;
      flt    = VECS[k].flt;
      host   = VECS[k].host;
      waitNeg(int'(VECS[k].waitCyc));
      chk($sformatf("R%0d vec%0d", VECS[k].req, k), "readyOut", ready0, VECS[k].expReady);
      chk($sformatf("R%0d vec%0d", VECS[k].req, k), "cardPresent", cp0, VECS[k].expCp);
      chk($sformatf("R8 vec%0d", k), "alarm", alarm0, ~VECS[k].expReady);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule